// File: doc/BRIEF.md
# Serial Bit-Rate Generator

This block produces the timing pulses that pace one serial channel. A single down-counter divides a selected source, either the block's own clock or an edge-detected external clock input, by a programmable value N+1. Each terminal count gives one single-cycle oversample tick. Two small prescalers, one for receive and one for transmit, turn that tick into a bit tick at x1, x8, x16 or x32 of the divided rate.

In asynchronous timing mode each direction uses its own ratio field. Normal use keeps the two fields equal. In synchronous mode both directions run at x1, so the bit tick is the divided tick itself. A pin clock can be enabled that changes level on every transmit bit tick, so that an external device can shift and sample on its edges.

The whole generator is held idle while its enable input is low. Re-enabling it restarts the divider from a full period.

Top module: `serial_rate_gen`

## Requirements
- R1: While reset is asserted and on the first cycle after it, os_tick, rx_bit_tick, tx_bit_tick and tx_clk_pin are all 0.
- R2: While gen_en is 0 no tick is produced and the pin clock stays 0. After gen_en rises, the first os_tick appears N+1 source pulses later.
- R3: With src_sel=0 every clock cycle is a source pulse. os_tick is a single-cycle pulse once every N+1 cycles, and N=0 gives a tick every cycle.
- R4: With src_sel=1 only rising edges of ext_clk_in count as source pulses. The os_tick period is N+1 external periods.
- R5: With async_mode=1, rx_ratio selects how many os_ticks make one rx_bit_tick: code 00 gives 1, 01 gives 8, 10 gives 16 and 11 gives 32. rx_bit_tick only appears together with os_tick. After enable, the first rx_bit_tick comes on the R-th os_tick.
- R6: tx_ratio uses the same codes for tx_bit_tick, independently of rx_ratio. tx_bit_tick only appears together with os_tick.
- R7: With async_mode=0, both bit ticks equal os_tick whatever the ratio fields hold.
- R8: A change of n_val takes effect only at the next terminal count. The period that is running completes with the old value.
- R9: With tx_clk_oe=1, tx_clk_pin changes level exactly on the cycles where tx_bit_tick is 1. With tx_clk_oe=0 it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the internal rate source |
| rst_n | input | 1 | Active-low synchronous reset |
| gen_en | input | 1 | Generator enable |
| src_sel | input | 1 | 0: internal clock, 1: external clock input |
| ext_clk_in | input | 1 | External rate source, asynchronous |
| n_val | input | NW | Divisor value; the rate is source/(N+1) |
| async_mode | input | 1 | 1: per-direction ratios apply, 0: x1 |
| rx_ratio | input | 2 | Receive ratio code |
| tx_ratio | input | 2 | Transmit ratio code |
| tx_clk_oe | input | 1 | Drive the transmit clock onto tx_clk_pin |
| os_tick | output | 1 | Divided-rate oversample tick |
| rx_bit_tick | output | 1 | Receive bit tick |
| tx_bit_tick | output | 1 | Transmit bit tick |
| tx_clk_pin | output | 1 | Transmit clock for a pin |

## Verification
The bench builds the block with its defaults: a 16-bit divisor and a two-stage synchronizer on the external input. Small N values (0 to 9) keep the x32 periods short, so every ratio code, the N=0 case, a mid-period change of N and a slow external clock all fit into short directed runs. Because the external clock is driven with a fixed period of six cycles, its tick spacing can be predicted exactly despite the synchronizer delay.

// File: rtl/serial_rate_gen.sv
module serial_rate_gen #(
  parameter int NW = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          gen_en,
  input  logic          src_sel,
  input  logic          ext_clk_in,
  input  logic [NW-1:0] n_val,
  input  logic          async_mode,
  input  logic [1:0]    rx_ratio,
  input  logic [1:0]    tx_ratio,
  input  logic          tx_clk_oe,
  output logic          os_tick,
  output logic          rx_bit_tick,
  output logic          tx_bit_tick,
  output logic          tx_clk_pin
);
  localparam int PW = 5;

  logic [SYNC_STAGES:0] ext_sh;
  logic [NW-1:0]        cnt;
  logic                 src_pulse, div_hit, pin_q;
  logic [1:0][1:0]      ratio;

  assign ratio = {tx_ratio, rx_ratio};

  function automatic logic [PW-1:0] lim_of(input logic [1:0] code, input logic am);
    logic [PW-1:0] l;
    case (code)
      2'b00:   l = PW'(0);
      2'b01:   l = PW'(7);
      2'b10:   l = PW'(15);
      default: l = PW'(31);
    endcase
    return am ? l : '0;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) ext_sh <= '0;
    else        ext_sh <= {ext_sh[SYNC_STAGES-1:0], ext_clk_in};
  end

  assign src_pulse = src_sel ? (ext_sh[SYNC_STAGES-1] & ~ext_sh[SYNC_STAGES]) : 1'b1;
  assign div_hit   = gen_en & src_pulse & (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)         cnt <= '0;
    else if (!gen_en)   cnt <= n_val;
    else if (src_pulse) cnt <= (cnt == '0) ? n_val : cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) os_tick <= 1'b0;
    else        os_tick <= div_hit;
  end

  for (genvar d = 0; d < 2; d++) begin : g_dir
    logic [PW-1:0] pc, lim;
    logic          hit_c, hit_q;
    assign lim   = lim_of(ratio[d], async_mode);
    assign hit_c = div_hit & (pc >= lim);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pc    <= '0;
        hit_q <= 1'b0;
      end else begin
        hit_q <= hit_c;
        if (!gen_en)     pc <= '0;
        else if (hit_c)  pc <= '0;
        else if (div_hit) pc <= pc + 1'b1;
      end
    end
  end

  assign rx_bit_tick = g_dir[0].hit_q;
  assign tx_bit_tick = g_dir[1].hit_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                pin_q <= 1'b0;
    else if (!gen_en)          pin_q <= 1'b0;
    else if (g_dir[1].hit_c)   pin_q <= ~pin_q;
  end

  assign tx_clk_pin = tx_clk_oe & pin_q;
endmodule

module serial_rate_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic gen_en,
  input logic async_mode,
  input logic tx_clk_oe,
  input logic os_tick,
  input logic rx_bit_tick,
  input logic tx_bit_tick,
  input logic tx_clk_pin
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_en |=> (!os_tick && !rx_bit_tick && !tx_bit_tick)); // R2
  AST_RX_ON_OS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_bit_tick |-> os_tick); // R5
  AST_TX_ON_OS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_bit_tick |-> os_tick); // R6
  AST_SYNC_X1: assert property (@(posedge clk) disable iff (!rst_n)
    (os_tick && $past(!async_mode)) |-> (rx_bit_tick && tx_bit_tick)); // R7
  AST_PIN_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_en && $past(gen_en) && tx_clk_oe && $past(tx_clk_oe) && !$stable(tx_clk_pin))
      |-> tx_bit_tick); // R9
endmodule

bind serial_rate_gen serial_rate_gen_chk chk_i (.*);

// File: tb/serial_rate_gen_tb_top.sv
`timescale 1ns/1ps
module serial_rate_gen_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        gen_en = 1'b0, src_sel = 1'b0, ext_clk_in = 1'b0, ext_run = 1'b0;
  logic [15:0] n_val = '0;
  logic        async_mode = 1'b1, tx_clk_oe = 1'b0;
  logic [1:0]  rx_ratio = 2'b00, tx_ratio = 2'b00;
  logic        os_tick, rx_bit_tick, tx_bit_tick, tx_clk_pin;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  serial_rate_gen dut_i (
    .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .src_sel(src_sel), .ext_clk_in(ext_clk_in),
    .n_val(n_val), .async_mode(async_mode), .rx_ratio(rx_ratio), .tx_ratio(tx_ratio),
    .tx_clk_oe(tx_clk_oe), .os_tick(os_tick), .rx_bit_tick(rx_bit_tick),
    .tx_bit_tick(tx_bit_tick), .tx_clk_pin(tx_clk_pin));

  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      if (ext_run) begin
        ph++;
        if (ph == 3) begin ph = 0; ext_clk_in = ~ext_clk_in; end
      end else begin
        ph = 0; ext_clk_in = 1'b0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_tick(input int sel, output int n);
    bit s;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      s = (sel == 0) ? os_tick : (sel == 1) ? rx_bit_tick : tx_bit_tick;
    end while (!s && n < 5000);
  endtask

  task automatic restart(input int n, input bit am, input logic [1:0] rr, input logic [1:0] tr);
    @(negedge clk);
    gen_en = 1'b0; n_val = 16'(n); async_mode = am; rx_ratio = rr; tx_ratio = tr;
    @(negedge clk);
    @(negedge clk);
    gen_en = 1'b1;
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk({os_tick, rx_bit_tick, tx_bit_tick, tx_clk_pin} == 4'b0, "R1 in reset",
        int'({os_tick, rx_bit_tick, tx_bit_tick, tx_clk_pin}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({os_tick, rx_bit_tick, tx_bit_tick, tx_clk_pin} == 4'b0, "R1 after reset",
        int'({os_tick, rx_bit_tick, tx_bit_tick, tx_clk_pin}), 0);
  endtask

  task automatic t_internal;
    int g;
    restart(4, 1'b1, 2'b00, 2'b00);
    wait_tick(0, g); chk(g == 5, "R2 first tick latency", g, 5);
    wait_tick(0, g); chk(g == 5, "R3 period N=4", g, 5);
    @(negedge clk);  chk(os_tick == 1'b0, "R3 single-cycle tick", int'(os_tick), 0);
    restart(0, 1'b1, 2'b00, 2'b00);
    wait_tick(0, g); chk(g == 1, "R3 N=0 latency", g, 1);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); chk(os_tick == 1'b1, "R3 N=0 every cycle", int'(os_tick), 1);
    end
  endtask

  task automatic t_external;
    int g;
    src_sel = 1'b1; ext_run = 1'b1;
    restart(2, 1'b1, 2'b00, 2'b00);
    wait_tick(0, g);
    wait_tick(0, g); chk(g == 18, "R4 external period", g, 18);
    wait_tick(0, g); chk(g == 18, "R4 external period again", g, 18);
    ext_run = 1'b0; src_sel = 1'b0;
  endtask

  task automatic t_ratios;
    int g;
    restart(1, 1'b1, 2'b01, 2'b10);
    wait_tick(1, g); chk(g == 16, "R5 rx x8 first bit tick", g, 16);
    wait_tick(1, g); chk(g == 16, "R5 rx x8 period", g, 16);
    restart(1, 1'b1, 2'b01, 2'b10);
    wait_tick(2, g); chk(g == 32, "R6 tx x16 first bit tick", g, 32);
    wait_tick(2, g); chk(g == 32, "R6 tx x16 period", g, 32);
    restart(1, 1'b1, 2'b11, 2'b00);
    wait_tick(1, g); chk(g == 64, "R5 rx x32 first bit tick", g, 64);
    wait_tick(1, g); chk(g == 64, "R5 rx x32 period", g, 64);
    wait_tick(2, g);
    wait_tick(2, g); chk(g == 2, "R6 tx x1 period", g, 2);
  endtask

  task automatic t_sync;
    int g;
    int bad = 0;
    restart(2, 1'b0, 2'b11, 2'b01);
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (rx_bit_tick != os_tick || tx_bit_tick != os_tick) bad++;
    end
    chk(bad == 0, "R7 bit ticks follow os_tick", bad, 0);
    wait_tick(1, g);
    wait_tick(1, g); chk(g == 3, "R7 rx x1 in sync mode", g, 3);
  endtask

  task automatic t_nchange;
    int g;
    restart(9, 1'b1, 2'b00, 2'b00);
    wait_tick(0, g);
    repeat (3) @(negedge clk);
    n_val = 16'd2;
    wait_tick(0, g); chk(g == 7, "R8 running period keeps old N", g + 3, 10);
    wait_tick(0, g); chk(g == 3, "R8 new N after terminal count", g, 3);
  endtask

  task automatic t_disable;
    int g;
    int bad = 0;
    restart(2, 1'b1, 2'b00, 2'b00);
    tx_clk_oe = 1'b1;
    repeat (7) @(negedge clk);
    gen_en = 1'b0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (os_tick || rx_bit_tick || tx_bit_tick || tx_clk_pin) bad++;
    end
    chk(bad == 0, "R2 quiet while disabled", bad, 0);
    gen_en = 1'b1;
    wait_tick(0, g); chk(g == 3, "R2 restart latency", g, 3);
    tx_clk_oe = 1'b0;
  endtask

  task automatic t_pin;
    int   toggles = 0, bad = 0;
    logic prev;
    restart(3, 1'b1, 2'b00, 2'b00);
    tx_clk_oe = 1'b1;
    @(negedge clk);
    prev = tx_clk_pin;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if ((tx_clk_pin != prev) != tx_bit_tick) bad++;
      if (tx_clk_pin != prev) toggles++;
      prev = tx_clk_pin;
    end
    chk(bad == 0, "R9 pin changes only on tx bit tick", bad, 0);
    chk(toggles == 10, "R9 pin toggle count", toggles, 10);
    tx_clk_oe = 1'b0;
    bad = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (tx_clk_pin) bad++;
    end
    chk(bad == 0, "R9 pin low when output disabled", bad, 0);
  endtask

  initial begin
    t_reset;
    t_internal;
    t_external;
    t_ratios;
    t_sync;
    t_nchange;
    t_disable;
    t_pin;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule